// File: doc/BRIEF.md
# Dual-Lane Constant-Coefficient Systolic Cell

This block is one processing element of a linear systolic array that computes two related convolutions side by side, one on each lane. Every cycle it takes four operands (a primary and an alternate operand for each lane), two partial sums and two control tags. The operands and tags go to the neighbouring cell after a single register stage. A pick tag chooses for both lanes whether the primary or the alternate operand is multiplied. The multiplier uses the cell's fixed coefficient and a small table of precomputed products.

The multiplier splits each two's-complement operand into a low and a high half. Each half addresses a table of 2^(OPW/2) entries, and the table is computed from the real-valued `COEF` parameter when the design is elaborated. The high-half entry is shifted left by OPW/2 and corrected for the operand sign before it is added to the low-half entry. A rounding shift then drops OPW/2 bits from the sum. Lane 1 adds or subtracts its product according to the negate tag. Lane 2 always adds or always subtracts, depending on the `LANE2_SUB` parameter. The partial sums come out four cycles after they go in, so the array schedule can line up the lanes of neighbouring cells.

Top module: `sysmac_cell`

## Requirements
- R1: `opa1_o`, `opb1_o`, `opa2_o`, `opb2_o`, `pick_o` and `neg1_o` equal the matching inputs sampled at the previous rising clock edge.
- R2: While `rst_n` is low, every output is zero.
- R3: `pick_i`=1 makes lane 1 use `opa1_i` and lane 2 use `opa2_i`. `pick_i`=0 makes them use `opb1_i` and `opb2_i`. The operand that is not chosen has no effect on the sums.
- R4: `neg1_i`=1 makes lane 1 subtract its product from `acc1_i`. `neg1_i`=0 makes it add the product.
- R5: Lane 2 adds its product to `acc2_i` when `LANE2_SUB`=0 and subtracts it when `LANE2_SUB`=1.
- R6: Each lane's output equals its partial sum plus or minus COEF·x·2^(FRACW−1−OPW/2) within ±2 LSB, where x is the signed operand chosen. The output appears at the fourth rising edge after the inputs are sampled.
- R7: A chosen operand of zero leaves the partial sum exactly unchanged on that lane.
- R8: R6 also holds at the operand extremes −2^(OPW−1) and 2^(OPW−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa1_i | input | OPW | Lane 1 primary operand, two's complement |
| opb1_i | input | OPW | Lane 1 alternate operand |
| opa2_i | input | OPW | Lane 2 primary operand |
| opb2_i | input | OPW | Lane 2 alternate operand |
| pick_i | input | 1 | 1 selects primary operands, 0 alternate |
| neg1_i | input | 1 | 1 makes lane 1 subtract its product |
| acc1_i | input | SUMW | Lane 1 incoming partial sum |
| acc2_i | input | SUMW | Lane 2 incoming partial sum |
| opa1_o | output | OPW | Registered copy of opa1_i |
| opb1_o | output | OPW | Registered copy of opb1_i |
| opa2_o | output | OPW | Registered copy of opa2_i |
| opb2_o | output | OPW | Registered copy of opb2_i |
| pick_o | output | 1 | Registered copy of pick_i |
| neg1_o | output | 1 | Registered copy of neg1_i |
| acc1_o | output | SUMW | Lane 1 updated partial sum |
| acc2_o | output | SUMW | Lane 2 updated partial sum |

## Verification
The properties assume that the partial sums stay inside the SUMW range, so that the wrap-around of modular addition never changes the result. The bench keeps its partial sums within 16 bits, which leaves wide margin in the default 24-bit sum path. The lane-sign property assumes that equal chosen operands give bit-identical products on both lanes, so the bench feeds the same operand to both lanes in several vectors. Every vector is held for the full four-cycle latency, so the sums at the output always come from one consistent set of inputs.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;

  // Round a real value to the nearest integer, with ties going away from zero.
  function automatic longint rnd_real(input real r);
    if (r >= 0.0) begin
      return longint'($rtoi(r + 0.5));
    end
    return -longint'($rtoi(0.5 - r));
  endfunction

  localparam int LANES = 2;

endpackage

// File: rtl/sysmac_opsel.sv
// Stage 1: pass-through registers, operand choice, lane sign, partial sum capture.
module sysmac_opsel #(
  parameter int OPW       = 8,
  parameter int SUMW      = 24,
  parameter bit LANE2_SUB = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OPW-1:0]            opa1_i,
  input  logic [OPW-1:0]            opb1_i,
  input  logic [OPW-1:0]            opa2_i,
  input  logic [OPW-1:0]            opb2_i,
  input  logic                      pick_i,
  input  logic                      neg1_i,
  input  logic [SUMW-1:0]           acc1_i,
  input  logic [SUMW-1:0]           acc2_i,
  output logic [OPW-1:0]            opa1_o,
  output logic [OPW-1:0]            opb1_o,
  output logic [OPW-1:0]            opa2_o,
  output logic [OPW-1:0]            opb2_o,
  output logic                      pick_o,
  output logic                      neg1_o,
  output logic [1:0][OPW-1:0]       sel_o,
  output logic [1:0]                neg_o,
  output logic [1:0][SUMW-1:0]      acc_o
);

  logic [1:0][OPW-1:0]  sel_d;
  logic [1:0]           neg_d;
  logic [1:0][SUMW-1:0] acc_d;

  always_comb begin
    sel_d[0] = pick_i ? opa1_i : opb1_i;
    sel_d[1] = pick_i ? opa2_i : opb2_i;
    neg_d[0] = neg1_i;
    neg_d[1] = LANE2_SUB;
    acc_d[0] = acc1_i;
    acc_d[1] = acc2_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa1_o <= '0;
      opb1_o <= '0;
      opa2_o <= '0;
      opb2_o <= '0;
      pick_o <= 1'b0;
      neg1_o <= 1'b0;
      sel_o  <= '0;
      neg_o  <= '0;
      acc_o  <= '0;
    end else begin
      opa1_o <= opa1_i;
      opb1_o <= opb1_i;
      opa2_o <= opa2_i;
      opb2_o <= opb2_i;
      pick_o <= pick_i;
      neg1_o <= neg1_i;
      sel_o  <= sel_d;
      neg_o  <= neg_d;
      acc_o  <= acc_d;
    end
  end

endmodule

// File: rtl/sysmac_cmul.sv
// Stages 2 and 3: constant multiplier built from a half-operand product table.
module sysmac_cmul #(
  parameter int  OPW   = 8,
  parameter int  FRACW = 12,
  parameter real COEF  = 1.2469796037,
  localparam int HW    = OPW / 2,
  localparam int TW    = FRACW + HW + 1,
  localparam int SW    = TW + HW + 1,
  localparam int PRW   = SW - HW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OPW-1:0]        op_i,
  output logic signed [PRW-1:0] prod_o
);

  localparam int     TBL_N  = 2 ** HW;
  localparam longint KCOR_L = sysmac_pkg::rnd_real(COEF * (2.0 ** HW) * (2.0 ** (FRACW - 1)));
  localparam logic signed [TW-1:0] KCOR = KCOR_L[TW-1:0];
  localparam logic signed [SW-1:0] RND  = SW'(1) <<< (HW - 1);

  logic signed [TW-1:0] tbl [TBL_N];

  // The coefficient table: entry v holds round(COEF * v * 2^(FRACW-1)).
  for (genvar v = 0; v < TBL_N; v++) begin : g_tbl
    localparam longint ENT = sysmac_pkg::rnd_real(COEF * real'(v) * (2.0 ** (FRACW - 1)));
    assign tbl[v] = ENT[TW-1:0];
  end

  logic [HW-1:0]        lo_idx, hi_idx;
  logic signed [TW-1:0] lo_d, hi_d, lo_q, hi_q;
  logic signed [SW-1:0] sum_d;
  logic signed [PRW-1:0] prod_d;

  // Stage 2 next state: the two table reads, plus the sign correction for the high half.
  always_comb begin
    lo_idx = op_i[HW-1:0];
    hi_idx = op_i[OPW-1:HW];
    lo_d   = tbl[lo_idx];
    hi_d   = op_i[OPW-1] ? (tbl[hi_idx] - KCOR) : tbl[hi_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // Stage 3 next state: a hardwired shift aligns the high half, then the sum is rounded.
  always_comb begin
    sum_d  = (SW'(hi_q) <<< HW) + SW'(lo_q) + RND;
    prod_d = sum_d[SW-1:HW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o <= '0;
    end else begin
      prod_o <= prod_d;
    end
  end

endmodule

// File: rtl/sysmac_acc.sv
// Delays the partial sum and sign to meet the product, then stage 4 accumulates.
module sysmac_acc #(
  parameter int SUMW = 24,
  parameter int PRW  = 18,
  parameter int LAT  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SUMW-1:0]       acc_i,
  input  logic                  neg_i,
  input  logic signed [PRW-1:0] prod_i,
  output logic [SUMW-1:0]       acc_o
);

  logic [SUMW-1:0] acc_pipe [LAT+1];
  logic            neg_pipe [LAT+1];
  logic [SUMW-1:0] acc_d;

  assign acc_pipe[0] = acc_i;
  assign neg_pipe[0] = neg_i;

  for (genvar s = 0; s < LAT; s++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_pipe[s+1] <= '0;
        neg_pipe[s+1] <= 1'b0;
      end else begin
        acc_pipe[s+1] <= acc_pipe[s];
        neg_pipe[s+1] <= neg_pipe[s];
      end
    end
  end

  always_comb begin
    if (neg_pipe[LAT]) begin
      acc_d = acc_pipe[LAT] - SUMW'(prod_i);
    end else begin
      acc_d = acc_pipe[LAT] + SUMW'(prod_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
    end else begin
      acc_o <= acc_d;
    end
  end

endmodule

// File: rtl/sysmac_cell.sv
module sysmac_cell #(
  parameter int  OPW       = 8,
  parameter int  FRACW     = 12,
  parameter int  SUMW      = 24,
  parameter real COEF      = 1.2469796037,
  parameter bit  LANE2_SUB = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OPW-1:0]  opa1_i,
  input  logic [OPW-1:0]  opb1_i,
  input  logic [OPW-1:0]  opa2_i,
  input  logic [OPW-1:0]  opb2_i,
  input  logic            pick_i,
  input  logic            neg1_i,
  input  logic [SUMW-1:0] acc1_i,
  input  logic [SUMW-1:0] acc2_i,
  output logic [OPW-1:0]  opa1_o,
  output logic [OPW-1:0]  opb1_o,
  output logic [OPW-1:0]  opa2_o,
  output logic [OPW-1:0]  opb2_o,
  output logic            pick_o,
  output logic            neg1_o,
  output logic [SUMW-1:0] acc1_o,
  output logic [SUMW-1:0] acc2_o
);

  localparam int HW      = OPW / 2;
  localparam int TW      = FRACW + HW + 1;
  localparam int PRW     = TW + 1;
  localparam int MUL_LAT = 2;
  localparam int NL      = sysmac_pkg::LANES;

  logic [NL-1:0][OPW-1:0]  sel_q;
  logic [NL-1:0]           neg_q;
  logic [NL-1:0][SUMW-1:0] acc_q;
  logic [NL-1:0][SUMW-1:0] acc_res;

  sysmac_opsel #(
    .OPW(OPW), .SUMW(SUMW), .LANE2_SUB(LANE2_SUB)
  ) u_opsel (
    .clk(clk), .rst_n(rst_n),
    .opa1_i(opa1_i), .opb1_i(opb1_i), .opa2_i(opa2_i), .opb2_i(opb2_i),
    .pick_i(pick_i), .neg1_i(neg1_i), .acc1_i(acc1_i), .acc2_i(acc2_i),
    .opa1_o(opa1_o), .opb1_o(opb1_o), .opa2_o(opa2_o), .opb2_o(opb2_o),
    .pick_o(pick_o), .neg1_o(neg1_o),
    .sel_o(sel_q), .neg_o(neg_q), .acc_o(acc_q)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic signed [PRW-1:0] prod;

    sysmac_cmul #(
      .OPW(OPW), .FRACW(FRACW), .COEF(COEF)
    ) u_cmul (
      .clk(clk), .rst_n(rst_n), .op_i(sel_q[g]), .prod_o(prod)
    );

    sysmac_acc #(
      .SUMW(SUMW), .PRW(PRW), .LAT(MUL_LAT)
    ) u_acc (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_q[g]), .neg_i(neg_q[g]),
      .prod_i(prod), .acc_o(acc_res[g])
    );
  end

  assign acc1_o = acc_res[0];
  assign acc2_o = acc_res[1];

endmodule

// File: rtl/sysmac_chk.sv
module sysmac_chk #(
  parameter int OPW       = 8,
  parameter int SUMW      = 24,
  parameter bit LANE2_SUB = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OPW-1:0]  opa1_i,
  input logic [OPW-1:0]  opb1_i,
  input logic [OPW-1:0]  opa2_i,
  input logic [OPW-1:0]  opb2_i,
  input logic            pick_i,
  input logic            neg1_i,
  input logic [SUMW-1:0] acc1_i,
  input logic [SUMW-1:0] acc2_i,
  input logic [OPW-1:0]  opa1_o,
  input logic [OPW-1:0]  opb1_o,
  input logic [OPW-1:0]  opa2_o,
  input logic [OPW-1:0]  opb2_o,
  input logic            pick_o,
  input logic            neg1_o,
  input logic [SUMW-1:0] acc1_o,
  input logic [SUMW-1:0] acc2_o
);

  // Counts clock edges since reset, saturating at the pipeline depth.
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  AST_PASS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 3'd0) |-> (opa1_o == $past(opa1_i) && opb1_o == $past(opb1_i) &&
                         opa2_o == $past(opa2_i) && opb2_o == $past(opb2_i))); // R1

  AST_PASS_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 3'd0) |-> (pick_o == $past(pick_i) && neg1_o == $past(neg1_i))); // R1

  AST_ZERO_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && (($past(pick_i, 4) ? $past(opa1_i, 4) : $past(opb1_i, 4)) == '0))
    |-> (acc1_o == $past(acc1_i, 4))); // R7

  AST_ZERO_LANE2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && (($past(pick_i, 4) ? $past(opa2_i, 4) : $past(opb2_i, 4)) == '0))
    |-> (acc2_o == $past(acc2_i, 4))); // R7

  AST_LANE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 &&
     (($past(pick_i, 4) ? $past(opa1_i, 4) : $past(opb1_i, 4)) ==
      ($past(pick_i, 4) ? $past(opa2_i, 4) : $past(opb2_i, 4))))
    |-> ((acc1_o - $past(acc1_i, 4)) ==
         (($past(neg1_i, 4) ^ LANE2_SUB) ? (SUMW'(0) - (acc2_o - $past(acc2_i, 4)))
                                          : (acc2_o - $past(acc2_i, 4))))); // R4 R5

endmodule

bind sysmac_cell sysmac_chk #(
  .OPW(OPW), .SUMW(SUMW), .LANE2_SUB(LANE2_SUB)
) u_chk (.*);

// File: tb/sysmac_cell_test.sv
`timescale 1ns/1ps
module sysmac_cell_test;

  localparam int  OPW   = 8;
  localparam int  FRACW = 12;
  localparam int  SUMW  = 24;
  localparam real CF    = 1.2469796037;
  localparam real SCALE = 128.0; // 2^(FRACW-1-OPW/2)

  typedef struct packed {
    logic [7:0]  a1;
    logic [7:0]  b1;
    logic [7:0]  a2;
    logic [7:0]  b2;
    logic        pick;
    logic        neg1;
    logic [15:0] y1;
    logic [15:0] y2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'd25,  8'hFD, 8'd25,  8'd7,   1'b1, 1'b0, 16'd100,  16'hFFCE},
    '{8'd25,  8'hFD, 8'd25,  8'd7,   1'b1, 1'b1, 16'd100,  16'hFFCE},
    '{8'd3,   8'h9C, 8'd90,  8'h9C,  1'b0, 1'b0, 16'd500,  16'd20},
    '{8'd127, 8'd0,  8'h80,  8'd1,   1'b1, 1'b1, 16'd0,    16'd0},
    '{8'h80,  8'hFF, 8'd5,   8'd127, 1'b0, 1'b0, 16'hF000, 16'd300},
    '{8'd0,   8'd44, 8'd0,   8'hC0,  1'b1, 1'b0, 16'd1234, 16'hFCF7},
    '{8'd99,  8'd0,  8'h81,  8'd0,   1'b0, 1'b1, 16'h8001, 16'd7777},
    '{8'd64,  8'hC0, 8'hDF,  8'd90,  1'b0, 1'b1, 16'd11,   16'hFFF5},
    '{8'd1,   8'd1,  8'hFF,  8'hFF,  1'b1, 1'b0, 16'd0,    16'd0},
    '{8'h80,  8'd2,  8'h80,  8'd3,   1'b1, 1'b1, 16'd4000, 16'hE000}
  };

  logic            clk;
  logic            rst_n;
  logic [OPW-1:0]  opa1, opb1, opa2, opb2;
  logic            pick, neg1;
  logic [SUMW-1:0] acc1, acc2;
  logic [OPW-1:0]  oa1, ob1, oa2, ob2, ua1, ub1, ua2, ub2;
  logic            opick, oneg1, upick, uneg1;
  logic [SUMW-1:0] o1, o2, u1, u2;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  sysmac_cell #(.OPW(OPW), .FRACW(FRACW), .SUMW(SUMW), .COEF(CF), .LANE2_SUB(1'b0)) uut (
    .clk(clk), .rst_n(rst_n),
    .opa1_i(opa1), .opb1_i(opb1), .opa2_i(opa2), .opb2_i(opb2),
    .pick_i(pick), .neg1_i(neg1), .acc1_i(acc1), .acc2_i(acc2),
    .opa1_o(oa1), .opb1_o(ob1), .opa2_o(oa2), .opb2_o(ob2),
    .pick_o(opick), .neg1_o(oneg1), .acc1_o(o1), .acc2_o(o2)
  );

  sysmac_cell #(.OPW(OPW), .FRACW(FRACW), .SUMW(SUMW), .COEF(CF), .LANE2_SUB(1'b1)) uut_sub (
    .clk(clk), .rst_n(rst_n),
    .opa1_i(opa1), .opb1_i(opb1), .opa2_i(opa2), .opb2_i(opb2),
    .pick_i(pick), .neg1_i(neg1), .acc1_i(acc1), .acc2_i(acc2),
    .opa1_o(ua1), .opb1_o(ub1), .opa2_o(ua2), .opb2_o(ub2),
    .pick_o(upick), .neg1_o(uneg1), .acc1_o(u1), .acc2_o(u2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input logic [SUMW-1:0] act, input real exp);
    real diff;
    diff = $itor($signed(act)) - exp;
    n_chk++;
    if (diff > 2.0 || diff < -2.0) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%f", req, $signed(act), exp);
    end
  endtask

  function automatic real sext16(input logic [15:0] v);
    return $itor($signed(v));
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    logic [7:0] s1, s2;
    real e1, e2, e2s;
    @(negedge clk);
    opa1 = v.a1; opb1 = v.b1; opa2 = v.a2; opb2 = v.b2;
    pick = v.pick; neg1 = v.neg1;
    acc1 = {{8{v.y1[15]}}, v.y1};
    acc2 = {{8{v.y2[15]}}, v.y2};
    @(negedge clk);
    // R1: one register to the neighbouring cell
    check_eq("R1 pass-through", longint'({oa1, ob1, oa2, ob2, opick, oneg1}),
             longint'({v.a1, v.b1, v.a2, v.b2, v.pick, v.neg1}));
    repeat (3) @(negedge clk);
    s1  = v.pick ? v.a1 : v.b1;
    s2  = v.pick ? v.a2 : v.b2;
    e1  = sext16(v.y1) + (v.neg1 ? -1.0 : 1.0) * CF * $itor($signed(s1)) * SCALE;
    e2  = sext16(v.y2) + CF * $itor($signed(s2)) * SCALE;
    e2s = sext16(v.y2) - CF * $itor($signed(s2)) * SCALE;
    check_near($sformatf("R3 R4 R6 R8 lane1 vec%0d", idx), o1, e1);
    check_near($sformatf("R3 R5 R6 R8 lane2 add vec%0d", idx), o2, e2);
    check_near($sformatf("R3 R5 R6 lane2 sub vec%0d", idx), u2, e2s);
    if (s1 == 8'd0) check_eq("R7 lane1 zero", longint'($signed(o1)), longint'(sext16(v.y1)));
    if (s2 == 8'd0) check_eq("R7 lane2 zero", longint'($signed(o2)), longint'(sext16(v.y2)));
  endtask

  initial begin
    rst_n = 1'b1;
    opa1 = 8'd17; opb1 = 8'd33; opa2 = 8'd5; opb2 = 8'd9;
    pick = 1'b1; neg1 = 1'b1;
    acc1 = 24'd999; acc2 = 24'd55;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: reset clears everything even with busy inputs
    check_eq("R2 reset ops", longint'({oa1, ob1, oa2, ob2, opick, oneg1}), 0);
    check_eq("R2 reset acc1", longint'(o1), 0);
    check_eq("R2 reset acc2", longint'(o2), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], i);
    end

    // R6 latency: a new set of inputs does not reach the sums before the fourth edge
    @(negedge clk);
    opa1 = 8'd0; pick = 1'b1; neg1 = 1'b0; acc1 = 24'd4321;
    repeat (3) @(negedge clk);
    check_near("R6 latency not yet", o1, 4000.0 - CF * (-128.0) * SCALE);
    @(negedge clk);
    check_eq("R6 latency arrived R7", longint'($signed(o1)), 4321);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule